// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the pin timing of a single external machine cycle for a small 8-bit processor whose low address byte and data byte share one set of pins. The core hands it a request: the cycle kind (opcode fetch, memory read, memory write, port read, port write), a 16-bit address and a write byte. The sequencer walks through its T-states and drives the high address byte, the shared address/data bus with its output enable, the address latch strobe, three status lines and two active-low strobes. It returns the byte it read and a one-clock completion pulse. On an opcode fetch it takes the address from its own program counter, advances that counter and loads the fetched byte into an instruction register.

The block is clocked at twice the T-state rate. Each T-state is two clocks, phase 0 then phase 1. The latch strobe is high only in phase 0 of T1, so its falling edge lands at mid-T1. A request is taken only in the idle state.

States: `ST_IDLE` waits. Accept (`req_valid` with a legal kind) moves to `ST_T1`. `ST_T1` goes to `ST_T2`, and `ST_T2` goes to `ST_T3`, each after phase 1. After phase 1 of `ST_T3`, a fetch moves to `ST_T4` and any other kind returns to `ST_IDLE` with `done`. `ST_T4` returns to `ST_IDLE` with `done` after its phase 1.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request is accepted only in the idle state and only with kind code 0 (opcode fetch), 1 (memory read), 2 (memory write), 3 (port read) or 4 (port write). A request made while busy, or with a code from 5 to 7, is ignored.
- R2: Memory and port cycles take 3 T-states (6 clocks) with `busy` high. An opcode fetch takes 4 T-states (8 clocks). `done` is high for exactly the one clock after the last T-state, and `busy` is low in that clock.
- R3: `ale` is high only in the first clock of T1. During T1 the address is on `addr_hi` (high byte) and `ad_out` (low byte), with `ad_oe` high and both strobes high.
- R4: While busy, the status lines {io_m,s1,s0} are 0,1,1 for a fetch, 0,1,0 for a memory read, 0,0,1 for a memory write, 1,1,0 for a port read and 1,0,1 for a port write. They do not change during the cycle.
- R5: In a port cycle the port number, taken from `req_addr[7:0]`, appears on both `addr_hi` and `ad_out` during T1.
- R6: `rd_n` is low during T2 and T3 of fetch and read cycles only. `wr_n` is low during T2 and T3 of write cycles only. The two are never low together.
- R7: In a write cycle, `ad_out` carries the write byte with `ad_oe` high during T2 and T3.
- R8: In a read or fetch cycle, `ad_oe` is low during T2 and T3. `ad_in` is sampled at the end of T3, and the sampled byte is on `rdata` when `done` is high.
- R9: A fetch uses `pc` as its address. `pc` goes up by one after the first clock of T2. The fetched byte is loaded into `ir`.
- R10: In T4 and when idle, both strobes are high and `ad_oe` and `ale` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 3 | Cycle kind code (see R1) |
| req_addr | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata | input | 8 | Byte to write |
| ad_in | input | 8 | Byte seen on the shared bus pins |
| addr_hi | output | 8 | High address byte pins |
| ad_out | output | 8 | Value driven on the shared bus |
| ad_oe | output | 1 | Output enable for the shared bus |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | High for port cycles |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rdata | output | 8 | Last byte read |
| ir | output | 8 | Last opcode fetched |
| pc | output | 16 | Program counter |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions check on every clock that the latch pulse lasts one clock and never overlaps a strobe, that the strobes never overlap, that the bus is released while reading, that the status lines stay fixed during a cycle and that the idle pins are quiet. Cycle length, the byte on each pin in each T-state, the port-number mirroring, the counter step and the capture of read data can only be shown by the bench. The bench sweeps every kind over edge addresses and compares each pin in every clock against values it derives from the T-state index. It also sends requests while busy and with illegal codes.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4
    } tstate_e;

    localparam logic [2:0] KIND_LAST = 3'd4;

    function automatic logic kind_reads(input kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_writes(input kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic logic kind_port(input kind_e k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

endpackage

// File: rtl/tstate_fsm.sv
module tstate_fsm
    import busseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    accept,
    input  logic    fetch_q,
    output tstate_e state,
    output logic    phase,
    output logic    done
);

    tstate_e state_nx;
    logic    done_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            phase <= (state_nx == ST_IDLE) ? 1'b0 : (state == ST_IDLE ? 1'b0 : ~phase);
            done  <= done_nx;
        end
    end

    always_comb begin
        state_nx = state;
        done_nx  = 1'b0;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_T1;
            ST_T1:   if (phase) state_nx = ST_T2;
            ST_T2:   if (phase) state_nx = ST_T3;
            ST_T3:   if (phase) begin
                         if (fetch_q) begin
                             state_nx = ST_T4;
                         end else begin
                             state_nx = ST_IDLE;
                             done_nx  = 1'b1;
                         end
                     end
            ST_T4:   if (phase) begin
                         state_nx = ST_IDLE;
                         done_nx  = 1'b1;
                     end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/req_capture.sv
module req_capture
    import busseq_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter logic [15:0] PC_RESET = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  kind_e             kind_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] ad_in,
    input  tstate_e           state,
    input  logic              phase,
    output kind_e             kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ir
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic bump_evt;
    logic cap_evt;

    assign bump_evt = (state == ST_T2) && !phase && (kind_q == K_FETCH);
    assign cap_evt  = (state == ST_T3) && phase && kind_reads(kind_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            pc      <= PC_RESET[ADDR_W-1:0];
            rdata   <= '0;
            ir      <= '0;
        end else begin
            if (accept) begin
                kind_q  <= kind_in;
                wdata_q <= wdata_in;
                if (kind_in == K_FETCH)
                    addr_q <= pc;
                else if (kind_port(kind_in))
                    addr_q <= {{(HI_W-DATA_W){1'b0}}, addr_in[DATA_W-1:0], addr_in[DATA_W-1:0]};
                else
                    addr_q <= addr_in;
            end
            if (bump_evt)
                pc <= pc + 1'b1;
            if (cap_evt) begin
                rdata <= ad_in;
                if (kind_q == K_FETCH)
                    ir <= ad_in;
            end
        end
    end

endmodule

// File: rtl/pin_encode.sv
module pin_encode
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  tstate_e           state,
    input  logic              phase,
    input  kind_e             kind_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              io_m,
    output logic              s1,
    output logic              s0,
    output logic              rd_n,
    output logic              wr_n
);

    logic strobe_win;

    always_comb begin
        addr_hi    = '0;
        ad_out     = '0;
        ad_oe      = 1'b0;
        ale        = 1'b0;
        io_m       = 1'b0;
        s1         = 1'b0;
        s0         = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        strobe_win = 1'b0;
        if (state != ST_IDLE) begin
            addr_hi = addr_q[ADDR_W-1:DATA_W];
            io_m    = kind_port(kind_q);
            s1      = kind_reads(kind_q);
            s0      = kind_writes(kind_q) || (kind_q == K_FETCH);
        end
        unique case (state)
            ST_IDLE: ;
            ST_T1: begin
                ale    = !phase;
                ad_out = addr_q[DATA_W-1:0];
                ad_oe  = 1'b1;
            end
            ST_T2, ST_T3: begin
                strobe_win = 1'b1;
                if (kind_writes(kind_q)) begin
                    ad_out = wdata_q;
                    ad_oe  = 1'b1;
                end
            end
            ST_T4: ;
            default: ;
        endcase
        rd_n = !(strobe_win && kind_reads(kind_q));
        wr_n = !(strobe_win && kind_writes(kind_q));
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import busseq_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter logic [15:0] PC_RESET = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              io_m,
    output logic              s1,
    output logic              s0,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ir,
    output logic [ADDR_W-1:0] pc,
    output logic              busy,
    output logic              done
);

    tstate_e           state;
    logic              phase;
    logic              accept;
    kind_e             kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign busy   = (state != ST_IDLE);
    assign accept = req_valid && !busy && (req_kind <= KIND_LAST);

    tstate_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .fetch_q (kind_q == K_FETCH),
        .state   (state),
        .phase   (phase),
        .done    (done)
    );

    req_capture #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PC_RESET (PC_RESET)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .kind_in  (kind_e'(req_kind)),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .ad_in    (ad_in),
        .state    (state),
        .phase    (phase),
        .kind_q   (kind_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .pc       (pc),
        .rdata    (rdata),
        .ir       (ir)
    );

    pin_encode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .state   (state),
        .phase   (phase),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .addr_hi (addr_hi),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ale     (ale),
        .io_m    (io_m),
        .s1      (s1),
        .s0      (s0),
        .rd_n    (rd_n),
        .wr_n    (wr_n)
    );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ad_oe,
    input logic ale,
    input logic io_m,
    input logic s1,
    input logic s0,
    input logic rd_n,
    input logic wr_n,
    input logic busy,
    input logic done
);

    // R3
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R3
    ale_quiet_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && ad_oe));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R8
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R4
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({io_m, s1, s0}));

    // R4
    port_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_m |-> (s1 != s0));

    // R2
    done_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && !ad_oe && !ale));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ad_oe (ad_oe),
    .ale   (ale),
    .io_m  (io_m),
    .s1    (s1),
    .s0    (s0),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .busy  (busy),
    .done  (done)
);

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic [7:0]  ad_in = 8'h0;
    logic [7:0]  addr_hi, ad_out, rdata, ir;
    logic        ad_oe, ale, io_m, s1, s0, rd_n, wr_n, busy, done;
    logic [15:0] pc;

    int checks = 0;
    int errors = 0;
    logic [15:0] pc_exp = 16'h0;

    always #2 clk = ~clk;

    bus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
        .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
        .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n),
        .rdata(rdata), .ir(ir), .pc(pc), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_cycle(input int kind, input logic [15:0] a, input logic [7:0] wd,
                             input logic [7:0] rb, input bit noise);
        int n;
        bit rd, wr, port;
        logic [7:0] hi, lo;
        logic [15:0] pc0;
        n    = (kind == 0) ? 8 : 6;
        rd   = (kind == 0) || (kind == 1) || (kind == 3);
        wr   = (kind == 2) || (kind == 4);
        port = (kind == 3) || (kind == 4);
        pc0  = pc_exp;
        if (kind == 0) begin hi = pc0[15:8]; lo = pc0[7:0]; end
        else if (port) begin hi = a[7:0]; lo = a[7:0]; end
        else begin hi = a[15:8]; lo = a[7:0]; end
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(kind); req_addr = a; req_wdata = wd; ad_in = rb;
        @(negedge clk);
        if (noise) begin
            req_kind = 3'd2; req_addr = 16'hDEAD; req_wdata = 8'h77;
        end else begin
            req_valid = 1'b0;
        end
        for (int c = 0; c < n; c++) begin
            int t;
            bit ph;
            t  = c / 2;
            ph = (c % 2) == 1;
            if (c == n - 1) req_valid = 1'b0;
            chk("R2", "busy", int'(busy), 1);
            chk("R2", "done mid", int'(done), 0);
            chk("R3", "ale", int'(ale), int'(t == 0 && !ph));
            chk("R4", "status", int'({io_m, s1, s0}),
                int'({port, rd, wr || kind == 0}));
            chk("R6", "rd_n", int'(rd_n), int'(!(rd && (t == 1 || t == 2))));
            chk("R6", "wr_n", int'(wr_n), int'(!(wr && (t == 1 || t == 2))));
            chk("R8", "ad_oe", int'(ad_oe), int'(t == 0 || (wr && (t == 1 || t == 2))));
            if (t == 0) begin
                chk("R5", "addr_hi", int'(addr_hi), int'(hi));
                chk("R3", "ad_out addr", int'(ad_out), int'(lo));
            end
            if (wr && (t == 1 || t == 2))
                chk("R7", "ad_out data", int'(ad_out), int'(wd));
            if (t == 3)
                chk("R10", "T4 quiet", int'({rd_n, wr_n, ad_oe, ale}), 4'b1100);
            if (kind == 0)
                chk("R9", "pc step", int'(pc), int'((c >= 3) ? pc0 + 16'd1 : pc0));
            @(negedge clk);
        end
        chk("R2", "done", int'(done), 1);
        chk("R2", "busy end", int'(busy), 0);
        chk("R10", "idle pins", int'({rd_n, wr_n, ad_oe, ale}), 4'b1100);
        if (rd) chk("R8", "rdata", int'(rdata), int'(rb));
        if (kind == 0) begin
            chk("R9", "ir", int'(ir), int'(rb));
            pc_exp = pc0 + 16'd1;
        end
        chk("R9", "pc end", int'(pc), int'(pc_exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] addrs [5];
        addrs[0] = 16'h0000; addrs[1] = 16'hFFFF; addrs[2] = 16'h5A3C;
        addrs[3] = 16'h00FF; addrs[4] = 16'h8001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "reset pins", int'({rd_n, wr_n, ad_oe, ale}), 4'b1100);
        chk("R2", "reset busy", int'(busy), 0);
        chk("R2", "reset done", int'(done), 0);
        chk("R9", "reset pc", int'(pc), 0);
        // R1: illegal kind codes leave the block idle
        for (int k = 5; k < 8; k++) begin
            req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h1234;
            @(negedge clk);
            req_valid = 1'b0;
            for (int w = 0; w < 3; w++) begin
                chk("R1", "illegal kind busy", int'(busy), 0);
                chk("R1", "illegal kind strobes", int'({rd_n, wr_n}), 2'b11);
                @(negedge clk);
            end
        end
        // R1: requests held high while busy are ignored (noise on odd steps)
        for (int i = 0; i < 5; i++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] wd, rb;
                wd = addrs[i][7:0] ^ 8'(k * 37 + 1);
                rb = ~addrs[i][15:8] ^ 8'(k);
                run_cycle(k, addrs[i], wd, rb, ((i + k) % 2) == 1);
            end
        end
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule